// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. When a start request arrives while it is idle, it connects an external integrator to the unknown input for a fixed window of 2^N clock periods. It then leaves the integrator unconnected for one clock. Next it connects the integrator to the negative reference and counts clock periods until the external comparator reports that the integrator output has come back to zero. That count is the conversion code, D = 2^N·Vin/Vref. The clock rate and the integrator time constant cancel out, so the logic needs no calibration values.

A single counter times both slopes. It is cleared between them. If the comparator has still not fallen after 2^N reference-phase clocks, the code saturates to all ones and an over-range flag is raised. Between conversions, a discharge output holds the integrator at zero. Each result is marked by a one-cycle completion pulse. The code and the flag then stay constant until the next completion pulse.

Top module: `dsadc_seq`

## Requirements
- R1: During and after reset, both phase selects are low, discharge is high, the completion pulse is low, the code is zero and the over-range flag is low.
- R2: A start request sampled high while idle raises the input-phase select on the next clock. That select then stays high for exactly 2^N consecutive clocks.
- R3: After the input phase ends, exactly one clock follows with both selects low. The reference-phase select rises on the clock after that.
- R4: The two phase selects are never high together. Discharge is never high while either select is high.
- R5: During the reference phase, the code is the number of reference-phase clocks on which the comparator was sampled high before the first clock on which it is sampled low (comparator high means the integrator output is above zero). A comparator sampled low on the first reference clock gives code 0.
- R6: On the clock after the comparator is sampled low, the reference select falls, discharge rises and the completion pulse is high. The pulse lasts exactly one clock.
- R7: If the comparator is sampled high on all 2^N reference-phase clocks, the reference phase ends after those 2^N clocks. The code is then all ones and the over-range flag is high; otherwise the flag is low.
- R8: A start request is ignored while a conversion is in progress. The phase lengths and the code are unaffected.
- R9: The code and the over-range flag change only in the clock where the completion pulse is high. They hold their values until the next completion pulse.
- R10: Discharge stays high from the end of a conversion until the next start request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| cmp_pos_i | input | 1 | Comparator: 1 while integrator output is above zero |
| sel_in_o | output | 1 | Connects the integrator to the unknown input |
| sel_ref_o | output | 1 | Connects the integrator to the negative reference |
| dump_o | output | 1 | Holds the integrator discharged |
| result_o | output | RES_BITS | Conversion code |
| done_o | output | 1 | One-clock completion pulse |
| ovr_o | output | 1 | Over-range flag for the held code |

## Verification
The assertions assume three things about the inputs. The comparator input is already synchronous to the clock. The comparator has a meaningful value only during the reference phase. A start request arrives only while the block is idle, or else is meant to be ignored. The bench meets these assumptions with a clocked integrator model. This model adds the input level on every input-phase clock, subtracts the reference on every reference-phase clock, clears on discharge, and reports its sign through nonblocking updates. A start pulse is injected part-way through the input phase to cover R8. Random input levels are drawn from 0 up to slightly above the reference, so that both the in-range codes and the over-range path are reached.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RUNUP   = 2'd1,
        ST_GAP     = 2'd2,
        ST_RUNDOWN = 2'd3
    } dsadc_state_e;

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         full_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_regs_t;

    cnt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.cnt = '0;
        end else if (inc_i) begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_o  = r_q.cnt;
    assign full_o = &r_q.cnt;

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
(
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic         cmp_pos_i,
    input  logic         full_i,
    output logic         cnt_clr_o,
    output logic         cnt_inc_o,
    output logic         finish_o,
    output logic         over_o,
    output logic         sel_in_o,
    output logic         sel_ref_o,
    output logic         dump_o
);

    typedef struct packed {
        dsadc_state_e state;
        logic         sel_in;
        logic         sel_ref;
        logic         dump;
    } ctrl_regs_t;

    ctrl_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        finish_o  = 1'b0;
        over_o    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                cnt_clr_o = 1'b1;
                if (start_i) begin
                    r_d.state = ST_RUNUP;
                end
            end
            ST_RUNUP: begin
                if (full_i) begin
                    cnt_clr_o = 1'b1;
                    r_d.state = ST_GAP;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_GAP: begin
                cnt_clr_o = 1'b1;
                r_d.state = ST_RUNDOWN;
            end
            ST_RUNDOWN: begin
                if (!cmp_pos_i) begin
                    finish_o  = 1'b1;
                    cnt_clr_o = 1'b1;
                    r_d.state = ST_IDLE;
                end else if (full_i) begin
                    finish_o  = 1'b1;
                    over_o    = 1'b1;
                    cnt_clr_o = 1'b1;
                    r_d.state = ST_IDLE;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
        r_d.sel_in  = (r_d.state == ST_RUNUP);
        r_d.sel_ref = (r_d.state == ST_RUNDOWN);
        r_d.dump    = (r_d.state == ST_IDLE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.state   <= ST_IDLE;
            r_q.sel_in  <= 1'b0;
            r_q.sel_ref <= 1'b0;
            r_q.dump    <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel_in_o  = r_q.sel_in;
    assign sel_ref_o = r_q.sel_ref;
    assign dump_o    = r_q.dump;

    p_sel_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_in_o && sel_ref_o));

    p_dump_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dump_o |-> (!sel_in_o && !sel_ref_o));

    p_runup_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.state == ST_RUNUP && !full_i) |=> sel_in_o);

    p_gap_after_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sel_in_o) |-> (!sel_ref_o && !dump_o));

    p_ref_after_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_ref_o) |-> $past(r_q.state == ST_GAP));

    p_start_only_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sel_in_o) |-> $past(dump_o && start_i));

    p_dump_holds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dump_o && !start_i) |=> dump_o);

endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         finish_i,
    input  logic         over_i,
    input  logic [W-1:0] cnt_i,
    output logic [W-1:0] result_o,
    output logic         ovr_o,
    output logic         done_o
);

    typedef struct packed {
        logic [W-1:0] result;
        logic         ovr;
        logic         done;
    } cap_regs_t;

    cap_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = finish_i;
        if (finish_i) begin
            r_d.ovr    = over_i;
            r_d.result = over_i ? {W{1'b1}} : cnt_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign result_o = r_q.result;
    assign ovr_o    = r_q.ovr;
    assign done_o   = r_q.done;

    p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    p_ovr_sat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovr_o |-> (&result_o));

    p_code_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(result_o) && $stable(ovr_o)));

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq #(
    parameter int RES_BITS = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                start_i,
    input  logic                cmp_pos_i,
    output logic                sel_in_o,
    output logic                sel_ref_o,
    output logic                dump_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o,
    output logic                ovr_o
);

    logic                cnt_clr;
    logic                cnt_inc;
    logic                cnt_full;
    logic [RES_BITS-1:0] cnt;
    logic                finish;
    logic                over;

    dsadc_counter #(.W(RES_BITS)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt),
        .full_o (cnt_full)
    );

    dsadc_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .start_i   (start_i),
        .cmp_pos_i (cmp_pos_i),
        .full_i    (cnt_full),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .finish_o  (finish),
        .over_o    (over),
        .sel_in_o  (sel_in_o),
        .sel_ref_o (sel_ref_o),
        .dump_o    (dump_o)
    );

    dsadc_capture #(.W(RES_BITS)) u_cap (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .finish_i (finish),
        .over_i   (over),
        .cnt_i    (cnt),
        .result_o (result_o),
        .ovr_o    (ovr_o),
        .done_o   (done_o)
    );

    p_finish_in_ref_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_o) |-> $past(sel_ref_o));

    p_end_dumps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (dump_o && !sel_ref_o));

endmodule

// File: tb/sim_dsadc_seq.sv
module sim_dsadc_seq;

    localparam int N    = 8;
    localparam int FULL = 1 << N;
    localparam int VREF = 100;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         cmp_pos;
    logic         sel_in, sel_ref, dump, done, ovr;
    logic [N-1:0] result;

    int  checks = 0;
    int  fails  = 0;
    int  vin_lvl = 0;
    int  integ = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    dsadc_seq #(.RES_BITS(N)) u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .start_i   (start),
        .cmp_pos_i (cmp_pos),
        .sel_in_o  (sel_in),
        .sel_ref_o (sel_ref),
        .dump_o    (dump),
        .result_o  (result),
        .done_o    (done),
        .ovr_o     (ovr)
    );

    // integrator model
    always @(posedge clk) begin
        if (dump)         integ <= 0;
        else if (sel_in)  integ <= integ + vin_lvl;
        else if (sel_ref) integ <= integ - VREF;
    end
    assign cmp_pos = (integ > 0);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_code(input int v);
        return (v * FULL + VREF - 1) / VREF;
    endfunction

    task automatic run_conv(input int v, input bit mid_start);
        int  n_in = 0, n_gap = 0, n_ref = 0, guard = 0;
        int  code, exp_res, exp_ref;
        bit  exp_ovr;
        bit  excl_ok = 1'b1, hold_ok = 1'b1;
        logic [N-1:0] prev_res = result;
        logic         prev_ovr = ovr;
        code = exp_code(v);
        if (code > FULL - 1) begin
            exp_ovr = 1'b1; exp_res = FULL - 1; exp_ref = FULL;
        end else begin
            exp_ovr = 1'b0; exp_res = code; exp_ref = code + 1;
        end
        vin_lvl = v;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(sel_in && !dump, "R2 input phase starts next clock", int'(sel_in), 1);
        while (!done && guard < 4 * FULL) begin
            if (sel_in) n_in++;
            else if (sel_ref) n_ref++;
            else if (n_in > 0 && n_ref == 0) n_gap++;
            if ((sel_in && sel_ref) || (dump && (sel_in || sel_ref))) excl_ok = 1'b0;
            if (result !== prev_res || ovr !== prev_ovr) hold_ok = 1'b0;
            start = (mid_start && guard == 5);
            @(negedge clk);
            guard++;
        end
        start = 1'b0;
        chk(done === 1'b1, "R6 completion pulse seen", int'(done), 1);
        chk(n_in == FULL, mid_start ? "R8 input phase length with extra start" : "R2 input phase length", n_in, FULL);
        chk(n_gap == 1, "R3 idle clock between phases", n_gap, 1);
        chk(n_ref == exp_ref, exp_ovr ? "R7 reference phase length" : "R5 reference phase length", n_ref, exp_ref);
        chk(excl_ok, "R4 select exclusivity", int'(excl_ok), 1);
        chk(hold_ok, "R9 code held during conversion", int'(hold_ok), 1);
        chk(int'(result) == exp_res, exp_ovr ? "R7 saturated code" : "R5 conversion code", int'(result), exp_res);
        chk(ovr == exp_ovr, "R7 over-range flag", int'(ovr), int'(exp_ovr));
        chk(dump && !sel_ref && !sel_in, "R6 discharge at end", int'(dump), 1);
        prev_res = result;
        @(negedge clk);
        chk(!done, "R6 pulse is one clock", int'(done), 0);
        chk(result == prev_res, "R9 code held after pulse", int'(result), int'(prev_res));
        repeat (3) @(negedge clk);
        chk(dump && !sel_in && !done, "R10 discharge held while idle", int'(dump), 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!sel_in && !sel_ref && dump && !done && result == '0 && !ovr,
            "R1 reset state", int'(dump), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sel_in && !sel_ref && dump && !done && result == '0 && !ovr,
            "R1 state after reset release", int'(result), 0);

        run_conv(0, 1'b0);        // R5 zero input
        run_conv(37, 1'b0);
        run_conv(50, 1'b1);       // R8 start ignored mid-conversion
        run_conv(99, 1'b0);       // R5 top of range
        run_conv(100, 1'b0);      // R7 exactly full scale
        run_conv(120, 1'b0);      // R7 well over range
        run_conv(1, 1'b0);
        for (int i = 0; i < 25; i++) begin
            run_conv($urandom_range(0, 110), ($urandom_range(0, 3) == 0));
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule